// File: doc/BRIEF.md
# IR Run-Length Receive Sampler

The sampler watches a demodulated infrared line and measures how long it stays in each state. A tick generator divides the clock into time units and counts a programmable number of units per sample period. At every sample the line is compared with the polarity of the run in progress. When the polarity changes, the finished run is packed into one byte: a 7-bit length in sample periods plus a flag that tells mark from space. That byte is written into an eight-byte buffer.

The buffer is split into two halves of four bytes each. A single indicator bit shows which half the hardware is filling. When a half is full, the indicator flips and an interrupt flag is raised. The flag stays high until software acknowledges it. A long silence ends a partly filled half early: a zero byte marks where the valid data stops, and the interrupt is raised.

Clearing and then setting the receive enable restarts the engine. This stops an endless series of space bytes, for example after a transmission. Software reads the buffer through a plain address/data port.

Top module: `irrl_sampler`

## Requirements
- R1: After reset, `irqPend` and `writeHalf` are 0 and every buffer byte reads 0x00.
- R2: The sample period is `samplePeriod` units when that value lies in 5..127; for any smaller value it is 50 units. One unit is UNIT_CYCLES clock cycles.
- R3: `irIn` = 1 is a mark. Each stored run byte has bit 7 = 1 for a space and bit 7 = 0 for a mark, and bits 6:0 = the run length in sample periods (never zero). A run's byte is written at the first sample of the opposite polarity.
- R4: With `overflowEn` = 1, a sample that would extend a run beyond 127 periods writes a byte of length 127. It then starts a new run of the same polarity with length 1.
- R5: With `overflowEn` = 0, a mark run stops counting at 127 and yields a single byte of length 127 when it ends.
- R6: Bytes go to address `{writeHalf, index}`, with the index running 0..3. Writing index 3 resets the index, flips `writeHalf` and sets `irqPend`.
- R7: With `overflowEn` = 0, a space sample after a 127-period space is treated as idle. If the index is nonzero, 0x00 is written at the current address, the half is completed as in R6, and the engine waits for a mark. If the index is zero, nothing is written and `writeHalf` does not change.
- R8: A one-cycle `irqAck` pulse clears `irqPend`. A completion in the same cycle wins and keeps it set.
- R9: While `rxEnable` is 0 the run is discarded and nothing is written. After enable, samples stay ignored until the first mark. The index, `writeHalf` and the buffer contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | Receive enable; a low pulse restarts the engine |
| overflowEn | input | 1 | 1: split long runs into 127 chunks; 0: saturate and detect idle |
| samplePeriod | input | 7 | Sample period in time units |
| irIn | input | 1 | Demodulated IR line, 1 = mark |
| irqAck | input | 1 | Interrupt acknowledge pulse |
| rdAddr | input | 3 | Buffer read address |
| rdData | output | 8 | Buffer byte at rdAddr |
| irqPend | output | 1 | Interrupt status: a half has been completed |
| writeHalf | output | 1 | Half currently being written |

## Verification
The embedded properties watch three things on every cycle:
- two sample ticks never fall on adjacent cycles;
- a flip of the write-half bit always comes with a pending interrupt, and an acknowledge without a completion clears that interrupt;
- a disabled engine is back in its waiting state, a run in progress never has zero length, and no run byte is ever zero.

The byte values themselves can only be shown by the bench scenarios, which read the buffer back. These cover run lengths and the space flag, the split into 127-period chunks against saturation, the idle terminator with and without a partial half, the fallback to the default period, and the fact that leading spaces after a restart are ignored.

// File: rtl/irrl_pkg.sv
package irrl_pkg;
  localparam int RUN_W = 7;
  localparam logic [RUN_W-1:0] RUN_FULL = '1;

  typedef enum logic {ST_WAIT, ST_RUN} irrl_state_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic clear;   // discard the run in progress
    logic start;   // begin a new run of length 1
    logic inc;     // extend the current run
    logic emit;    // store the current run byte
    logic term;    // store a zero byte and close the half
    logic level;   // synchronised line level at this sample
  } irrl_strobe_t;

  // datapath state reported back to control
  typedef struct packed {
    logic [RUN_W-1:0] count;
    logic             level;
    logic             idxZero;
  } irrl_status_t;
endpackage

// File: rtl/irrl_ctrl.sv
module irrl_ctrl
  import irrl_pkg::*;
#(
  parameter int UNIT_CYCLES    = 8,
  parameter int PERIOD_MIN     = 5,
  parameter int PERIOD_DEFAULT = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxEnable,
  input  logic             overflowEn,
  input  logic [RUN_W-1:0] samplePeriod,
  input  logic             irIn,
  input  irrl_status_t     stat,
  output irrl_strobe_t     stb
);
  localparam int UNIT_W = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;

  logic [1:0]       syncQ;
  logic             level;
  logic [UNIT_W-1:0] unitCnt;
  logic [RUN_W-1:0] periodCnt;
  logic [RUN_W-1:0] effPeriod;
  logic             unitTick;
  logic             sampleTick;
  irrl_state_e      state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= '0;
    else        syncQ <= {syncQ[0], irIn};
  end
  assign level = syncQ[1];

  assign effPeriod = (samplePeriod >= RUN_W'(PERIOD_MIN)) ? samplePeriod
                                                          : RUN_W'(PERIOD_DEFAULT);
  assign unitTick   = (unitCnt == UNIT_W'(UNIT_CYCLES - 1));
  assign sampleTick = rxEnable && unitTick && (periodCnt >= effPeriod - RUN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unitCnt   <= '0;
      periodCnt <= '0;
    end else if (!rxEnable) begin
      unitCnt   <= '0;
      periodCnt <= '0;
    end else if (unitTick) begin
      unitCnt   <= '0;
      periodCnt <= sampleTick ? '0 : periodCnt + RUN_W'(1);
    end else begin
      unitCnt   <= unitCnt + UNIT_W'(1);
    end
  end

  always_comb begin
    stb       = '0;
    stb.level = level;
    nextState = state;
    if (!rxEnable) begin
      stb.clear = 1'b1;
      nextState = ST_WAIT;
    end else if (sampleTick) begin
      if (state == ST_WAIT) begin
        if (level) begin
          stb.start = 1'b1;
          nextState = ST_RUN;
        end
      end else if (level != stat.level) begin
        stb.emit  = 1'b1;
        stb.start = 1'b1;
      end else if (stat.count != RUN_FULL) begin
        stb.inc = 1'b1;
      end else if (overflowEn) begin
        stb.emit  = 1'b1;
        stb.start = 1'b1;
      end else if (!level) begin
        stb.term  = !stat.idxZero;
        nextState = ST_WAIT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_WAIT;
    else        state <= nextState;
  end

  // R2: samples are spaced by at least five units
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sampleTick |=> !sampleTick);

  // R9: a disabled engine waits for a mark
  p_disable_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rxEnable |=> (state == ST_WAIT));

  // R3: a run in progress always has a nonzero length
  p_run_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (stat.count != '0));
endmodule

// File: rtl/irrl_datapath.sv
module irrl_datapath
  import irrl_pkg::*;
#(
  parameter int HALF_BYTES = 4,
  localparam int BUF_BYTES = 2 * HALF_BYTES,
  localparam int IDX_W     = $clog2(HALF_BYTES),
  localparam int ADDR_W    = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  irrl_strobe_t      stb,
  input  logic              irqAck,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              irqPend,
  output logic              writeHalf,
  output irrl_status_t      stat
);
  logic [RUN_W-1:0]          runCount;
  logic                      runLevel;
  logic [IDX_W-1:0]          wrIdx;
  logic                      lastIdx;
  logic                      setIrq;
  logic                      wrStrobe;
  logic [7:0]                wrByte;
  logic [ADDR_W-1:0]         wrAddr;
  logic [BUF_BYTES-1:0][7:0] cellArr;

  assign lastIdx  = (wrIdx == IDX_W'(HALF_BYTES - 1));
  assign setIrq   = (stb.emit && lastIdx) || stb.term;
  assign wrStrobe = stb.emit || stb.term;
  assign wrByte   = stb.term ? 8'h00 : {~runLevel, runCount};
  assign wrAddr   = {writeHalf, wrIdx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runCount <= '0;
      runLevel <= 1'b0;
    end else if (stb.clear) begin
      runCount <= '0;
      runLevel <= 1'b0;
    end else if (stb.start) begin
      runCount <= RUN_W'(1);
      runLevel <= stb.level;
    end else if (stb.inc) begin
      runCount <= runCount + RUN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrIdx     <= '0;
      writeHalf <= 1'b0;
    end else if (setIrq) begin
      wrIdx     <= '0;
      writeHalf <= ~writeHalf;
    end else if (stb.emit) begin
      wrIdx     <= wrIdx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irqPend <= 1'b0;
    else if (setIrq) irqPend <= 1'b1;
    else if (irqAck) irqPend <= 1'b0;
  end

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_cell
    logic [7:0] cellQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     cellQ <= '0;
      else if (wrStrobe && (wrAddr == ADDR_W'(g)))    cellQ <= wrByte;
    end
    assign cellArr[g] = cellQ;
  end

  assign rdData       = cellArr[rdAddr];
  assign stat.count   = runCount;
  assign stat.level   = runLevel;
  assign stat.idxZero = (wrIdx == '0);

  // R6: a half change always leaves the interrupt pending
  p_toggle_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (writeHalf != $past(writeHalf)) |-> irqPend);

  // R8: an acknowledge without a completion clears the flag
  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irqAck && !setIrq) |=> !irqPend);

  // R7: a run byte is never zero, so zero only marks the end
  p_no_zero_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.emit |-> (runCount != '0));
endmodule

// File: rtl/irrl_sampler.sv
module irrl_sampler
  import irrl_pkg::*;
#(
  parameter int UNIT_CYCLES    = 8,
  parameter int HALF_BYTES     = 4,
  parameter int PERIOD_MIN     = 5,
  parameter int PERIOD_DEFAULT = 50,
  localparam int ADDR_W        = $clog2(2 * HALF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxEnable,
  input  logic              overflowEn,
  input  logic [RUN_W-1:0]  samplePeriod,
  input  logic              irIn,
  input  logic              irqAck,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              irqPend,
  output logic              writeHalf
);
  irrl_strobe_t stb;
  irrl_status_t stat;

  irrl_ctrl #(
    .UNIT_CYCLES   (UNIT_CYCLES),
    .PERIOD_MIN    (PERIOD_MIN),
    .PERIOD_DEFAULT(PERIOD_DEFAULT)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rxEnable    (rxEnable),
    .overflowEn  (overflowEn),
    .samplePeriod(samplePeriod),
    .irIn        (irIn),
    .stat        (stat),
    .stb         (stb)
  );

  irrl_datapath #(
    .HALF_BYTES(HALF_BYTES)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .irqAck   (irqAck),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .irqPend  (irqPend),
    .writeHalf(writeHalf),
    .stat     (stat)
  );
endmodule

// File: tb/irrl_sampler_bench.sv
module irrl_sampler_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxEnable = 1'b0;
  logic       overflowEn = 1'b0;
  logic [6:0] samplePeriod = 7'd5;
  logic       irIn = 1'b0;
  logic       irqAck = 1'b0;
  logic [2:0] rdAddr = 3'd0;
  logic [7:0] rdData;
  logic       irqPend;
  logic       writeHalf;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // table-driven scenario: run levels, lengths in samples, expected buffer
  localparam int N_RUNS = 7;
  localparam int RUN_LVL   [N_RUNS] = '{1, 0, 1, 0, 1, 0, 1};
  localparam int RUN_TICKS [N_RUNS] = '{3, 2, 130, 5, 1, 2, 1};
  localparam int EXP_A [8] = '{'h03, 'h82, 'h7F, 'h03, 'h85, 'h01, 'h82, 'h00};

  always #4 clk = ~clk;

  irrl_sampler #(.UNIT_CYCLES(1)) u_irrl_sampler (
    .clk(clk), .rst_n(rst_n), .rxEnable(rxEnable), .overflowEn(overflowEn),
    .samplePeriod(samplePeriod), .irIn(irIn), .irqAck(irqAck),
    .rdAddr(rdAddr), .rdData(rdData), .irqPend(irqPend), .writeHalf(writeHalf)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkByte(input string req, input int addr, input int exp);
    rdAddr = 3'(addr);
    #1;
    chk(req, int'(rdData), exp);
  endtask

  task automatic restart(input int p, input logic oe);
    @(negedge clk);
    rxEnable = 1'b0;
    irIn = 1'b0;
    repeat (3) @(negedge clk);
    samplePeriod = 7'(p);
    overflowEn = oe;
    rxEnable = 1'b1;
  endtask

  task automatic runLevel(input logic lvl, input int ticks, input int p);
    irIn = lvl;
    repeat (ticks * p) @(negedge clk);
  endtask

  task automatic ackIrq();
    @(negedge clk);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 irqPend", int'(irqPend), 0);
    chk("R1 writeHalf", int'(writeHalf), 0);
    for (int a = 0; a < 8; a++) chkByte("R1 buffer", a, 0);

    // R3 R4 R6: table scenario, period 5, overflow split on
    restart(5, 1'b1);
    for (int i = 0; i < N_RUNS; i++) runLevel(RUN_LVL[i][0], RUN_TICKS[i], 5);
    for (int a = 0; a < 8; a++) chkByte("R3/R4 table byte", a, EXP_A[a]);
    chk("R6 half flipped", int'(writeHalf), 1);
    chk("R6 irq on full half", int'(irqPend), 1);

    // R8: acknowledge
    ackIrq();
    chk("R8 ack clears", int'(irqPend), 0);
    chk("R8 half unchanged", int'(writeHalf), 1);

    // R9: restart ignores leading space, keeps index
    restart(5, 1'b0);
    runLevel(1'b0, 10, 5);
    chkByte("R9 leading space ignored", 7, 'h00);
    runLevel(1'b1, 2, 5);
    runLevel(1'b0, 140, 5);
    chkByte("R9 index kept across restart", 7, 'h02);
    chk("R6 half flipped back", int'(writeHalf), 0);
    // R7: idle with index zero writes nothing
    chkByte("R7 no terminator on empty half", 0, 'h03);
    chk("R7 irq from completion", int'(irqPend), 1);
    ackIrq();

    // R7: idle after partial half writes terminator
    restart(5, 1'b0);
    runLevel(1'b1, 2, 5);
    runLevel(1'b0, 140, 5);
    chkByte("R7 run before idle", 0, 'h02);
    chkByte("R7 zero terminator", 1, 'h00);
    chkByte("R7 single terminator", 2, 'h7F);
    chk("R7 half closed", int'(writeHalf), 1);
    chk("R7 irq raised", int'(irqPend), 1);
    ackIrq();

    // R2: out-of-range period falls back to 50 units
    restart(3, 1'b1);
    runLevel(1'b1, 3, 50);
    runLevel(1'b0, 1, 50);
    runLevel(1'b1, 1, 50);
    chkByte("R2 default period mark", 4, 'h03);
    chkByte("R2 default period space", 5, 'h81);
    chk("R2 no completion yet", int'(irqPend), 0);

    // R5: mark saturates when overflow split is off
    restart(5, 1'b0);
    runLevel(1'b1, 140, 5);
    runLevel(1'b0, 1, 5);
    runLevel(1'b1, 1, 5);
    chkByte("R5 saturated mark", 6, 'h7F);
    chkByte("R5 no extra chunk", 7, 'h81);
    chk("R5 half completed", int'(writeHalf), 0);
    chk("R5 irq raised", int'(irqPend), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule